// File: doc/BRIEF.md
# Wiper Command Execution Engine

This block carries out the short commands that a serial front end has already decoded for a bank of digital potentiometer wiper registers. Each command is a 4-bit code, sent together with a channel select. Depending on the code, the command acts on the selected channel or on every channel in the same cycle. The commands cover single-step moves up and down, doubling and halving of the wiper code (a change of ±6 dB), copying a wiper into nonvolatile storage, reloading wipers from that storage, and a no-operation. The wiper width is a parameter. Use 6 for 64-step parts and 8 for 256-step parts.

The nonvolatile storage array is outside the block. The engine reads all stored words in parallel, and it writes a word by giving a per-channel write strobe together with the data. A single down-counter models the slow operations as whole numbers of clock cycles: the store time and the reload time. While the counter runs, `busy` is high. The host must poll `busy` and wait for it to fall, and the engine drops any command that arrives in the meantime.

After reset, every wiper holds midscale and `busy` is high for the reload time. At the end of that time, all wipers take their stored values at once.

Top module: `wiper_cmd_engine`

## Requirements
- R1: While reset is held, each wiper reads midscale (only the top bit set), `busy` is 1 and the write strobes are 0.
- R2: After reset is released, `busy` stays high for exactly RESTORE_CYCLES clock cycles. In the cycle where it falls, every wiper equals its stored word.
- R3: Linear increment adds one to the wiper and stays at full scale (all ones) when the wiper is already at full scale. Code 10 acts on the selected channel and code 11 acts on all channels.
- R4: Linear decrement subtracts one from the wiper and stays at zero when the wiper is already zero. Code 5 acts on the selected channel and code 6 acts on all channels.
- R5: The +6 dB command (code 8 for one channel, code 9 for all) works as follows:
  - a wiper at zero becomes 1;
  - a wiper with its top bit set becomes full scale;
  - any other wiper is shifted left by one.

  Starting from zero, full scale is therefore reached after W+1 steps and not before.
- R6: The -6 dB command (code 3 for one channel, code 4 for all) shifts the wiper right by one. Starting from full scale, zero is reached after W steps and not before.
- R7: A single-channel command changes only the channel whose index equals `cmd_ch`. Channel i occupies bits [i*W +: W] of the wiper and stored-data vectors.
- R8: Code 1 copies the stored word of the selected channel into its wiper on the next clock edge and does not raise `busy`.
- R9: Code 2 sets the selected channel's bit of `nv_wr_en` for exactly one cycle, with `nv_wr_data` carrying the current wipers. It then holds `busy` high for exactly STORE_CYCLES cycles, counted from the accepting edge, and leaves the wipers unchanged.
- R10: Code 7 holds `busy` high for RESTORE_CYCLES cycles. In the cycle where `busy` falls, every wiper is loaded from its stored word.
- R11: The following have no effect on the wipers or on the write strobes:
  - any command given while `busy` is high;
  - code 0;
  - the unused codes 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the power-up sequence |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 4 | Command code (0 to 15) |
| cmd_ch | input | CH_W | Channel index for single-channel commands |
| busy | output | 1 | A timed store or reload is in progress |
| wiper | output | NCH*W | Wiper registers, channel i at [i*W +: W] |
| nv_rd_data | input | NCH*W | Stored words read from the nonvolatile array |
| nv_wr_en | output | NCH | One-cycle write strobe per channel |
| nv_wr_data | output | NCH*W | Data to write, channel i at [i*W +: W] |

## Verification
The hardest states to reach from the ports are the two ends of the shift range: a wiper at exactly zero before a doubling, and a wiper with only the top bit set just before it saturates. No single command gets there from an arbitrary value. The stimulus first halves all channels W times, checking each intermediate value, until both channels reach zero. It then doubles them W+1 times and checks that full scale appears on the last step and not one step earlier. The refused-while-busy case is reached by giving a store and, in the very next cycle, an all-channel increment that must leave the wipers unchanged.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;

  // Command codes as decoded by the serial front end
  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_LOAD1      = 4'd1,
    CMD_SAVE1      = 4'd2,
    CMD_HALVE1     = 4'd3,
    CMD_HALVE_ALL  = 4'd4,
    CMD_DEC1       = 4'd5,
    CMD_DEC_ALL    = 4'd6,
    CMD_RELOAD_ALL = 4'd7,
    CMD_DOUBLE1    = 4'd8,
    CMD_DOUBLE_ALL = 4'd9,
    CMD_INC1       = 4'd10,
    CMD_INC_ALL    = 4'd11
  } qcmd_e;

  // Per-channel arithmetic selection
  typedef enum logic [2:0] {
    OP_HOLD, OP_INC, OP_DEC, OP_DBL, OP_HLV, OP_LOAD
  } step_op_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_RESTORE, PH_STORE
  } timer_phase_e;

endpackage

// File: rtl/wiper_step_unit.sv
module wiper_step_unit
  import wiper_cmd_pkg::*;
#(
  parameter int W = 8
) (
  input  step_op_e       op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   nv_val,
  output logic [W-1:0]   nxt
);

  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] f_inc(input logic [W-1:0] v);
    return (v == FULL) ? FULL : v + ONE;
  endfunction

  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  // +6 dB: zero seeds to one, a set top bit clamps, otherwise shift left
  function automatic logic [W-1:0] f_dbl(input logic [W-1:0] v);
    if (v == '0)   return ONE;
    if (v[W-1])    return FULL;
    return {v[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] f_hlv(input logic [W-1:0] v);
    return {1'b0, v[W-1:1]};
  endfunction

  always_comb begin
    case (op)
      OP_INC:  nxt = f_inc(cur);
      OP_DEC:  nxt = f_dec(cur);
      OP_DBL:  nxt = f_dbl(cur);
      OP_HLV:  nxt = f_hlv(cur);
      OP_LOAD: nxt = nv_val;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer
  import wiper_cmd_pkg::*;
#(
  parameter int RESTORE_CYCLES = 30000,
  parameter int STORE_CYCLES   = 2600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_store,
  input  logic start_reload,
  output logic busy,
  output logic load_all
);

  localparam int MAXC  = (RESTORE_CYCLES > STORE_CYCLES) ? RESTORE_CYCLES : STORE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RLD_TOP = CNT_W'(RESTORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] STO_TOP = CNT_W'(STORE_CYCLES - 1);

  timer_phase_e     phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RESTORE;
      cnt_q   <= RLD_TOP;
    end else if (phase_q != PH_IDLE) begin
      if (cnt_q == '0) phase_q <= PH_IDLE;
      else             cnt_q   <= cnt_q - 1'b1;
    end else if (start_store) begin
      phase_q <= PH_STORE;
      cnt_q   <= STO_TOP;
    end else if (start_reload) begin
      phase_q <= PH_RESTORE;
      cnt_q   <= RLD_TOP;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign load_all = (phase_q == PH_RESTORE) && (cnt_q == '0);

  // R2/R10: a reload window always ends in an idle phase
  p_reload_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_all |=> !busy);

  // R9: a store never starts while another timed operation runs
  p_store_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && phase_q == PH_STORE) |-> $past(start_store));

endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
  import wiper_cmd_pkg::*;
#(
  parameter int W              = 8,
  parameter int NCH            = 2,
  parameter int RESTORE_CYCLES = 30000,
  parameter int STORE_CYCLES   = 2600000,
  localparam int CH_W          = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_code,
  input  logic [CH_W-1:0]      cmd_ch,
  output logic                 busy,
  output logic [NCH*W-1:0]     wiper,
  input  logic [NCH*W-1:0]     nv_rd_data,
  output logic [NCH-1:0]       nv_wr_en,
  output logic [NCH*W-1:0]     nv_wr_data
);

  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FULL = {W{1'b1}};

  // Named internal events
  logic           accept;
  logic           start_store;
  logic           start_reload;
  logic           load_all;
  qcmd_e          code;
  step_op_e       op_sel;
  logic [NCH-1:0] mask_sel;
  logic [NCH-1:0] one_mask;
  logic [NCH-1:0] nv_wr_en_q;

  assign code         = qcmd_e'(cmd_code);
  assign accept       = cmd_valid && !busy;
  assign start_store  = accept && (code == CMD_SAVE1);
  assign start_reload = accept && (code == CMD_RELOAD_ALL);
  assign one_mask     = NCH'(1) << cmd_ch;

  always_comb begin
    op_sel   = OP_HOLD;
    mask_sel = '0;
    case (code)
      CMD_LOAD1:      begin op_sel = OP_LOAD; mask_sel = one_mask; end
      CMD_HALVE1:     begin op_sel = OP_HLV;  mask_sel = one_mask; end
      CMD_HALVE_ALL:  begin op_sel = OP_HLV;  mask_sel = '1;       end
      CMD_DEC1:       begin op_sel = OP_DEC;  mask_sel = one_mask; end
      CMD_DEC_ALL:    begin op_sel = OP_DEC;  mask_sel = '1;       end
      CMD_DOUBLE1:    begin op_sel = OP_DBL;  mask_sel = one_mask; end
      CMD_DOUBLE_ALL: begin op_sel = OP_DBL;  mask_sel = '1;       end
      CMD_INC1:       begin op_sel = OP_INC;  mask_sel = one_mask; end
      CMD_INC_ALL:    begin op_sel = OP_INC;  mask_sel = '1;       end
      default:        ;
    endcase
  end

  wiper_busy_timer #(
    .RESTORE_CYCLES (RESTORE_CYCLES),
    .STORE_CYCLES   (STORE_CYCLES)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_store  (start_store),
    .start_reload (start_reload),
    .busy         (busy),
    .load_all     (load_all)
  );

  logic [W-1:0] wiper_q [NCH];
  step_op_e     op_ch   [NCH];
  logic [W-1:0] nxt_ch  [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign op_ch[i] = load_all                 ? OP_LOAD :
                      (accept && mask_sel[i])  ? op_sel  : OP_HOLD;

    wiper_step_unit #(.W(W)) u_step (
      .op     (op_ch[i]),
      .cur    (wiper_q[i]),
      .nv_val (nv_rd_data[i*W +: W]),
      .nxt    (nxt_ch[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) wiper_q[i] <= MID;
      else        wiper_q[i] <= nxt_ch[i];
    end

    assign wiper[i*W +: W]      = wiper_q[i];
    assign nv_wr_data[i*W +: W] = wiper_q[i];

    p_inc_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ch[i] == OP_INC && wiper_q[i] == FULL) |=> wiper_q[i] == FULL);

    p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ch[i] == OP_DEC && wiper_q[i] == '0) |=> wiper_q[i] == '0);

    p_double_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ch[i] == OP_DBL && wiper_q[i] != FULL) |=> wiper_q[i] > $past(wiper_q[i]));

    p_halve_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ch[i] == OP_HLV && wiper_q[i] != '0) |=> wiper_q[i] < $past(wiper_q[i]));

    p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ch[i] == OP_HOLD) |=> $stable(wiper_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nv_wr_en_q <= '0;
    else        nv_wr_en_q <= start_store ? one_mask : '0;
  end
  assign nv_wr_en = nv_wr_en_q;

  p_busy_refuses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_all) |=> $stable(wiper));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|nv_wr_en) |-> ($onehot0(nv_wr_en) && busy));

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|nv_wr_en) |=> (nv_wr_en == '0));

  p_reload_values_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_all |=> (wiper == $past(nv_rd_data)));

endmodule

// File: tb/wiper_cmd_engine_test.sv
module wiper_cmd_engine_test;

  localparam int W    = 8;
  localparam int NCH  = 2;
  localparam int RC   = 20;
  localparam int SC   = 40;
  localparam int FULL = (1 << W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [3:0]       cmd_code = '0;
  logic [0:0]       cmd_ch = '0;
  logic             busy;
  logic [NCH*W-1:0] wiper;
  logic [NCH*W-1:0] nv_rd_data;
  logic [NCH-1:0]   nv_wr_en;
  logic [NCH*W-1:0] nv_wr_data;

  always #5 clk = ~clk;

  wiper_cmd_engine #(.W(W), .NCH(NCH), .RESTORE_CYCLES(RC), .STORE_CYCLES(SC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ch(cmd_ch), .busy(busy), .wiper(wiper), .nv_rd_data(nv_rd_data),
    .nv_wr_en(nv_wr_en), .nv_wr_data(nv_wr_data)
  );

  // Bench-owned nonvolatile array
  logic [W-1:0] nv_mem [NCH] = '{8'h5A, 8'hC3};
  always @(posedge clk)
    for (int i = 0; i < NCH; i++)
      if (nv_wr_en[i]) nv_mem[i] <= nv_wr_data[i*W +: W];
  always_comb
    for (int i = 0; i < NCH; i++) nv_rd_data[i*W +: W] = nv_mem[i];

  int    checks = 0;
  int    errors = 0;
  longint cyc = 0;
  bit    done = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    longint           due;
    logic [NCH*W-1:0] val;
    string            req;
  } exp_t;
  exp_t scb [$];

  int mdl [NCH];

  function automatic logic [NCH*W-1:0] pack_mdl();
    logic [NCH*W-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*W +: W] = W'(mdl[i]);
    return v;
  endfunction

  function automatic int up6(int v);
    if (v == 0) return 1;
    if (v * 2 > FULL) return FULL;
    return v * 2;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_apply(input int code, input int ch);
    for (int i = 0; i < NCH; i++) begin
      bit hit;
      hit = (i == ch);
      case (code)
        1:  if (hit) mdl[i] = nv_mem[i];
        3:  if (hit) mdl[i] = mdl[i] / 2;
        4:  mdl[i] = mdl[i] / 2;
        5:  if (hit && mdl[i] > 0) mdl[i] = mdl[i] - 1;
        6:  if (mdl[i] > 0) mdl[i] = mdl[i] - 1;
        8:  if (hit) mdl[i] = up6(mdl[i]);
        9:  mdl[i] = up6(mdl[i]);
        10: if (hit && mdl[i] < FULL) mdl[i] = mdl[i] + 1;
        11: if (mdl[i] < FULL) mdl[i] = mdl[i] + 1;
        default: ;
      endcase
    end
  endtask

  // Driver: one-cycle command, expected wiper pushed to the scoreboard
  task automatic issue(input int code, input int ch, input bit refused, input string req);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = 4'(code);
    cmd_ch    = 1'(ch);
    if (!refused) model_apply(code, ch);
    e.due = cyc + 1;
    e.val = pack_mdl();
    e.req = req;
    scb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: compare each expected item in its cycle
  initial forever begin
    @(negedge clk);
    if (scb.size() > 0 && scb[0].due <= cyc) begin
      exp_t e;
      e = scb.pop_front();
      chk(wiper == e.val, e.req, wiper, e.val);
    end
  end

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wiper == {NCH{8'h80}}, "R1 midscale", wiper, {NCH{8'h80}});
    chk(busy == 1'b1, "R1 busy", busy, 1);
    chk(nv_wr_en == '0, "R1 strobe", nv_wr_en, 0);
    rst_n = 1'b1;
    // R2: power-up reload
    busy_len(n);
    chk(n == RC, "R2 busy length", n, RC);
    chk(wiper == {nv_mem[1], nv_mem[0]}, "R2 loaded", wiper, {nv_mem[1], nv_mem[0]});
    for (int i = 0; i < NCH; i++) mdl[i] = nv_mem[i];

    // R3/R4/R7: linear steps, single and all channels
    issue(10, 0, 0, "R7 inc one");
    issue(11, 0, 0, "R3 inc all");
    issue(5, 1, 0, "R7 dec one");
    issue(6, 0, 0, "R4 dec all");
    issue(8, 1, 0, "R7 double one");
    issue(3, 0, 0, "R7 halve one");

    // R6: halve all to zero within W steps
    for (int k = 0; k < W; k++) issue(4, 0, 0, "R6 halve all");
    issue(6, 0, 0, "R4 dec at zero");
    // R5: W+1 doublings from zero
    for (int k = 0; k < W; k++) issue(9, 0, 0, "R5 double all");
    @(negedge clk);
    chk(wiper[W-1:0] == 8'h80, "R5 not full after W steps", wiper[W-1:0], 8'h80);
    issue(9, 0, 0, "R5 double to full");
    @(negedge clk);
    chk(wiper == '1, "R5 full after W+1", wiper, {NCH*W{1'b1}});
    issue(11, 0, 0, "R3 inc at full");
    issue(10, 1, 0, "R3 inc one at full");
    for (int k = 0; k < W; k++) issue(4, 0, 0, "R6 halve from full");
    @(negedge clk);
    chk(wiper == '0, "R6 zero after W", wiper, 0);

    // Build distinct values
    for (int k = 0; k < 5; k++) issue(10, 0, 0, "R3 climb ch0");
    for (int k = 0; k < 9; k++) issue(10, 1, 0, "R3 climb ch1");

    // R9: store channel 1
    issue(2, 1, 0, "R9 wiper kept");
    chk(nv_wr_en == 2'b10, "R9 strobe", nv_wr_en, 2'b10);
    chk(nv_wr_data[2*W-1:W] == W'(mdl[1]), "R9 data", nv_wr_data[2*W-1:W], mdl[1]);
    busy_len(n);
    chk(n == SC, "R9 busy length", n, SC);
    chk(nv_wr_en == '0, "R9 strobe ends", nv_wr_en, 0);
    chk(nv_mem[1] == W'(mdl[1]), "R9 stored", nv_mem[1], mdl[1]);

    // R11: refused while busy
    issue(2, 0, 0, "R9 store ch0");
    issue(11, 0, 1, "R11 inc while busy");
    issue(2, 1, 1, "R11 store while busy");
    busy_len(n);
    chk(nv_mem[0] == W'(mdl[0]) && nv_mem[1] == W'(mdl[1]), "R11 memory", {nv_mem[1], nv_mem[0]}, pack_mdl());
    issue(0, 0, 1, "R11 nop");
    issue(13, 1, 1, "R11 reserved code");
    @(negedge clk);
    chk(nv_wr_en == '0 && !busy, "R11 reserved no strobe", nv_wr_en, 0);

    // R8: single restore
    issue(11, 0, 0, "R7 move away");
    issue(1, 1, 0, "R8 restore one");
    chk(busy == 1'b0, "R8 no busy", busy, 0);

    // R10: reload all
    issue(11, 0, 0, "R7 move again");
    issue(7, 0, 1, "R10 held during reload");
    busy_len(n);
    chk(n == RC, "R10 busy length", n, RC);
    for (int i = 0; i < NCH; i++) mdl[i] = nv_mem[i];
    chk(wiper == pack_mdl(), "R10 reloaded", wiper, pack_mdl());

    repeat (3) @(negedge clk);
    chk(scb.size() == 0, "R7 scoreboard drained", scb.size(), 0);
    done = 1;
    summary();
  end

endmodule